// File: doc/BRIEF.md
# Branch Target Buffer

This block guesses the next fetch address. The fetch stage presents its current fetch address, and the lookup runs in the same cycle as the instruction cache read. A small direct-mapped table holds one tag and one target address per slot. If the slot chosen by the fetch address is valid and its tag matches, the block returns the stored target. If not, it returns the start of the next 16-byte fetch group, which is four 4-byte instructions ahead.

A separate update port reports a resolved control transfer: its address, whether it was taken, and its real target. A taken transfer writes its slot and replaces whatever was there. A not-taken report clears the slot only when that slot currently holds the same branch. A not-taken report never creates an entry, so the table holds only transfers that were actually taken. Direction prediction, return-address handling and pipeline flush belong to other blocks.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses until a taken update is written.
- R2: On a hit, `guess_hit` is 1 and `guess_pc` equals the stored target, both combinational from `fetch_pc` in the same cycle.
- R3: On a miss, `guess_hit` is 0 and `guess_pc` equals `fetch_pc + 16`, wrapping modulo 2^PC_W.
- R4: With default parameters the slot index is `fetch_pc[7:4]` and the tag is `fetch_pc[31:8]`. Bits [3:0] take no part in matching.
- R5: An update with `upd_valid`=1 and `upd_taken`=1 writes the tag and target and marks the slot valid. The new entry is visible to lookups from the cycle after the clock edge that takes the update.
- R6: An update with `upd_taken`=0 invalidates the slot only if that slot is valid and its tag matches `upd_pc`. Otherwise the table is unchanged, and no entry is ever allocated this way.
- R7: A taken update whose tag differs from the tag held at the same index replaces that entry, so the old branch then misses.
- R8: When a lookup and an update address the same slot in one cycle, the lookup returns the contents from before the update.
- R9: While `upd_valid` is 0, the update inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all valid bits |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| guess_hit | output | 1 | 1 when a stored entry matched |
| guess_pc | output | PC_W | Predicted next fetch address |
| upd_valid | input | 1 | An update is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved transfer |
| upd_taken | input | 1 | 1 when the transfer was taken |
| upd_target | input | PC_W | Real target of the resolved transfer |

## Verification
Lookup results are combinational, so the bench drives `fetch_pc` on the falling edge and samples `guess_hit` and `guess_pc` 2 ns later, in the same cycle with no register in the path. An update takes effect at the first rising edge while `upd_valid` is high. Its effect is therefore checked only after that edge, at the next falling edge. The read-before-write case is the exception: it samples in the very cycle the update is presented, before the edge, and expects the old contents.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int GROUP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            guess_hit,
  output logic [PC_W-1:0] guess_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W - GROUP_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(1 << GROUP_W);

  logic [SLOTS-1:0] live_q;
  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [PC_W-1:0]  tgt_q [SLOTS];

  wire [IDX_W-1:0] f_idx = fetch_pc[GROUP_W +: IDX_W];
  wire [TAG_W-1:0] f_tag = fetch_pc[PC_W-1 -: TAG_W];
  wire [IDX_W-1:0] u_idx = upd_pc[GROUP_W +: IDX_W];
  wire [TAG_W-1:0] u_tag = upd_pc[PC_W-1 -: TAG_W];

  assign guess_hit = live_q[f_idx] && (tag_q[f_idx] == f_tag);
  assign guess_pc  = guess_hit ? tgt_q[f_idx] : fetch_pc + STEP;

  wire u_match = live_q[u_idx] && (tag_q[u_idx] == u_tag);

  always_ff @(posedge clk) begin
    if (!rst_n)
      live_q <= '0;
    else if (upd_valid && upd_taken)
      live_q[u_idx] <= 1'b1;
    else if (upd_valid && u_match)
      live_q[u_idx] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (upd_valid && upd_taken) begin
      tag_q[u_idx] <= u_tag;
      tgt_q[u_idx] <= upd_target;
    end
  end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int PC_W    = 32,
  parameter int GROUP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic            guess_hit,
  input logic [PC_W-1:0] guess_pc,
  input logic            upd_valid,
  input logic [PC_W-1:0] upd_pc,
  input logic            upd_taken,
  input logic [PC_W-1:0] upd_target
);
  logic up_q;
  always_ff @(posedge clk) up_q <= rst_n;

  a_r1_empty_after_reset: assert property (@(posedge clk)
    (rst_n && !up_q) |-> !guess_hit);

  a_r3_miss_next_group: assert property (@(posedge clk) disable iff (!rst_n)
    !guess_hit |-> guess_pc == fetch_pc + PC_W'(1 << GROUP_W));

  a_r5_taken_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(upd_valid && upd_taken) && fetch_pc == $past(upd_pc))
      |-> (guess_hit && guess_pc == $past(upd_target)));

  a_r6_not_taken_gone: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(upd_valid && !upd_taken) && fetch_pc == $past(upd_pc))
      |-> !guess_hit);
endmodule

bind btb_predictor btb_predictor_chk #(.PC_W(PC_W), .GROUP_W(GROUP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .guess_hit(guess_hit),
  .guess_pc(guess_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
  .upd_taken(upd_taken), .upd_target(upd_target));

// File: tb/btb_predictor_test.sv
module btb_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        guess_hit;
  logic [31:0] guess_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  int n_chk = 0;
  int n_bad = 0;
  bit over = 1'b0;

  always #10 clk = ~clk;

  btb_predictor uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .guess_hit(guess_hit),
    .guess_pc(guess_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target));

  task automatic look(input logic [31:0] pc, input logic eh, input logic [31:0] ep,
                      input string req);
    fetch_pc = pc;
    #2;
    n_chk++;
    if (guess_hit !== eh || guess_pc !== ep) begin
      n_bad++;
      $display("FAIL %s pc=%h: hit=%b next=%h, expected hit=%b next=%h",
               req, pc, guess_hit, guess_pc, eh, ep);
    end
  endtask

  task automatic update(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset;
    look(32'h0000_1000, 1'b0, 32'h0000_1010, "R1");
    look(32'h0000_2024, 1'b0, 32'h0000_2034, "R1");
    look(32'hFFFF_FFF8, 1'b0, 32'h0000_0008, "R3 wrap");
  endtask

  task automatic t_alloc;
    update(32'h0000_1000, 1'b1, 32'h0000_2000);
    look(32'h0000_1000, 1'b1, 32'h0000_2000, "R5/R2");
    look(32'h0000_100C, 1'b1, 32'h0000_2000, "R4 offset bits");
    look(32'h0000_1010, 1'b0, 32'h0000_1020, "R4 index");
    look(32'h0001_1000, 1'b0, 32'h0001_1010, "R4 tag");
  endtask

  task automatic t_no_alloc;
    update(32'h0000_3040, 1'b0, 32'h0000_7000);
    look(32'h0000_3040, 1'b0, 32'h0000_3050, "R6 no alloc");
  endtask

  task automatic t_alias;
    update(32'h0001_1000, 1'b1, 32'h0000_0500);
    look(32'h0000_1000, 1'b0, 32'h0000_1010, "R7 old evicted");
    look(32'h0001_1000, 1'b1, 32'h0000_0500, "R7 new");
  endtask

  task automatic t_kill;
    update(32'h0000_1000, 1'b0, 32'h0);
    look(32'h0001_1000, 1'b1, 32'h0000_0500, "R6 other tag kept");
    update(32'h0001_1000, 1'b0, 32'h0);
    look(32'h0001_1000, 1'b0, 32'h0001_1010, "R6 invalidate");
  endtask

  task automatic t_rbw;
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h0000_2020; upd_taken = 1'b1; upd_target = 32'h0000_9000;
    look(32'h0000_2020, 1'b0, 32'h0000_2030, "R8 old contents");
    @(negedge clk);
    upd_valid = 1'b0;
    look(32'h0000_2020, 1'b1, 32'h0000_9000, "R5 after edge");
  endtask

  task automatic t_idle;
    @(negedge clk);
    upd_valid = 1'b0; upd_pc = 32'h0000_5050; upd_taken = 1'b1; upd_target = 32'h0000_AAAA;
    @(negedge clk);
    look(32'h0000_5050, 1'b0, 32'h0000_5060, "R9 idle taken");
    upd_pc = 32'h0000_2020; upd_taken = 1'b0;
    @(negedge clk);
    look(32'h0000_2020, 1'b1, 32'h0000_9000, "R9 idle kill");
  endtask

  task automatic finish_run;
    if (!over) begin
      over = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_alloc();
    t_no_alloc();
    t_alias();
    t_kill();
    t_rbw();
    t_idle();
    finish_run();
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule